// File: doc/BRIEF.md
# Credit-Based Flow Control Link

This block joins a flit source to a flit sink through a link whose sender never overruns the receiver's buffer. The sending side holds a credit counter that says how many receiver buffer slots are known to be free. A flit is accepted from the source only while that counter is nonzero, and each accepted flit costs one credit. The receiving side stores flits in a first-in first-out buffer that the downstream consumer drains with a ready signal.

Slots freed by the consumer are not returned one at a time. The receiver gathers them into a small batch and sends the batch back as one multi-unit count, which the sender adds to its counter. A batch leaves as soon as it holds two slots, or when its oldest slot has waited its maximum time. A send and a credit return can land in the same cycle, and the counter then applies both at once. The counter is clamped at the buffer depth, and any attempt to go past it raises an error flag that stays set until reset.

Top module: `credit_link`

## Requirements
- R1: While rst_n is low at a rising clock edge, the link resets: credit_count becomes DEPTH (8), src_ready is 1, dst_valid is 0 and link_err is 0.
- R2: A flit is accepted when src_valid and src_ready are both 1 at a rising edge. With no credit arriving in that cycle, credit_count is one lower after that edge.
- R3: A returned credit count is added to credit_count. When a flit is accepted in the same cycle that a return arrives, the counter becomes old value minus 1 plus the returned count.
- R4: src_ready equals 1 exactly when credit_count is nonzero. While it is 0, src_valid has no effect and no flit enters the buffer. src_ready rises again in the first cycle the counter becomes nonzero.
- R5: Accepted flits leave on dst_data in the order they were accepted. dst_valid is 1 exactly when the buffer holds a flit, and a flit is removed at each rising edge where dst_valid and dst_ready are both 1.
- R6: The receiver returns freed slots as one count on a 4-bit return field, never more than 2 at a time. A return is issued as soon as the batch reaches 2. A slot freed at a rising edge is credited to credit_count no later than the fifth rising edge after it.
- R7: credit_count never exceeds DEPTH. An update that would push it past DEPTH clamps the counter and sets link_err, which stays 1 until reset. Under legal operation link_err stays 0.
- R8: Once the link has been idle long enough for all batches to drain (5 cycles with no removal), credit_count equals DEPTH minus the number of flits held in the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| src_valid | input | 1 | Source offers a flit |
| src_data | input | DATA_W | Flit offered by the source |
| src_ready | output | 1 | Sender holds at least one credit |
| dst_valid | output | 1 | Receiver buffer holds a flit |
| dst_data | output | DATA_W | Oldest flit in the receiver buffer |
| dst_ready | input | 1 | Consumer takes the head flit |
| credit_count | output | $clog2(DEPTH+1) | Current credit counter |
| link_err | output | 1 | Sticky credit overflow flag |

## Verification
The assertions assume that the source and consumer only change their inputs between clock edges and that the only credit entering the counter is the count produced by this block's own return path, so the sum of credits, buffered flits and pending returns stays at the buffer depth. The stimulus drives src_valid and dst_ready at random with biased densities per phase, including long stretches with the consumer stalled so the counter sits at zero while the source keeps pushing. Directed sequences place a single freed slot to exercise the time-out return, two back-to-back removals to exercise the batch return, and a send in the exact cycle a return is applied.

// File: rtl/credit_link_pkg.sv
// Package: credit_link_pkg
// Shared defaults for the credit link: receiver depth, credit return width,
// batch size and the longest time a freed slot may wait before it is sent back.
package credit_link_pkg;
    localparam int CL_DEPTH     = 8;
    localparam int CL_DATA_W    = 16;
    localparam int CL_RET_W     = 4;
    localparam int CL_BATCH     = 2;
    localparam int CL_MAX_WAIT  = 4;

    // Wider of two widths plus one, used for overflow-safe sums.
    function automatic int cl_sum_width(input int a, input int b);
        return ((a > b) ? a : b) + 1;
    endfunction
endpackage

// File: rtl/cl_tx_credit.sv
// Module: cl_tx_credit
// Sender-side credit counter. Starts at DEPTH, drops by one per accepted
// flit, adds the returned count, and clamps at DEPTH with a sticky error.
// Assumes ret_cnt is zero except in cycles that carry a credit return.
module cl_tx_credit #(
    parameter int DEPTH = credit_link_pkg::CL_DEPTH,
    parameter int RET_W = credit_link_pkg::CL_RET_W,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_valid,
    input  logic [RET_W-1:0] ret_cnt,
    output logic             send,
    output logic             has_credit,
    output logic [CNT_W-1:0] credit,
    output logic             err
);
    localparam int SUM_W = credit_link_pkg::cl_sum_width(CNT_W, RET_W);

    logic [CNT_W-1:0] credit_q;
    logic             err_q;
    logic [SUM_W-1:0] next_sum;
    logic             over;

    // Accept decision and next counter value with both send and return applied.
    always_comb begin
        has_credit = (credit_q != '0);
        send       = src_valid && has_credit;
        next_sum   = SUM_W'(credit_q) + SUM_W'(ret_cnt) - SUM_W'(send);
        over       = (next_sum > SUM_W'(DEPTH));
    end

    // Counter and sticky overflow flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            credit_q <= CNT_W'(DEPTH);
            err_q    <= 1'b0;
        end else begin
            credit_q <= over ? CNT_W'(DEPTH) : next_sum[CNT_W-1:0];
            if (over) begin
                err_q <= 1'b1;
            end
        end
    end

    assign credit = credit_q;
    assign err    = err_q;
endmodule

// File: rtl/cl_rx_fifo.sv
// Module: cl_rx_fifo
// Receiver flit buffer, first-in first-out, DEPTH entries (power of two).
// Assumes the sender's credits prevent writes while full; such a write is
// dropped. Pops whenever the head is valid and the consumer is ready.
module cl_rx_fifo #(
    parameter int DEPTH  = credit_link_pkg::CL_DEPTH,
    parameter int DATA_W = credit_link_pkg::CL_DATA_W,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              pop,
    output logic              full
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     count;
    logic              push;

    // Handshake decode for both ends of the buffer.
    always_comb begin
        rd_valid = (count != '0);
        full     = (count == CW'(DEPTH));
        pop      = rd_valid && rd_ready;
        push     = wr_en && !full;
        rd_data  = mem[rd_ptr];
    end

    // Storage array: one slot per entry, written at the write pointer.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (push && (wr_ptr == AW'(i))) begin
                mem[i] <= wr_data;
            end
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + AW'(1);
            end
            if (pop) begin
                rd_ptr <= rd_ptr + AW'(1);
            end
            count <= count + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/cl_credit_return.sv
// Module: cl_credit_return
// Gathers slots freed by the receiver and returns them as one registered
// count. A batch is sent once it reaches BATCH, or when it has waited
// MAX_WAIT-1 cycles since its first slot. Assumes at most one pop per cycle.
module cl_credit_return #(
    parameter int RET_W    = credit_link_pkg::CL_RET_W,
    parameter int BATCH    = credit_link_pkg::CL_BATCH,
    parameter int MAX_WAIT = credit_link_pkg::CL_MAX_WAIT,
    localparam int WW      = (MAX_WAIT > 1) ? $clog2(MAX_WAIT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop,
    output logic [RET_W-1:0] ret_cnt
);
    logic [RET_W-1:0] pend_q;
    logic [WW-1:0]    wait_q;
    logic [RET_W-1:0] ret_q;
    logic [RET_W-1:0] acc;
    logic             flush;

    // Batch total this cycle and the decision to send it now.
    always_comb begin
        acc   = pend_q + RET_W'(pop);
        flush = (acc >= RET_W'(BATCH)) ||
                ((acc != '0) && (wait_q == WW'(MAX_WAIT - 1)));
    end

    // Batch, age and outgoing return registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            wait_q <= '0;
            ret_q  <= '0;
        end else if (flush) begin
            ret_q  <= acc;
            pend_q <= '0;
            wait_q <= '0;
        end else begin
            ret_q  <= '0;
            pend_q <= acc;
            wait_q <= (acc != '0) ? wait_q + WW'(1) : '0;
        end
    end

    assign ret_cnt = ret_q;
endmodule

// File: rtl/credit_link.sv
// Module: credit_link
// Top of the credit link: sender credit counter, receiver buffer and the
// batched credit return path between them. Flits cross the link in the
// cycle they are accepted; credits come back through one register stage.
module credit_link #(
    parameter int DEPTH    = credit_link_pkg::CL_DEPTH,
    parameter int DATA_W   = credit_link_pkg::CL_DATA_W,
    parameter int RET_W    = credit_link_pkg::CL_RET_W,
    parameter int BATCH    = credit_link_pkg::CL_BATCH,
    parameter int MAX_WAIT = credit_link_pkg::CL_MAX_WAIT,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    output logic              dst_valid,
    output logic [DATA_W-1:0] dst_data,
    input  logic              dst_ready,
    output logic [CNT_W-1:0]  credit_count,
    output logic              link_err
);
    logic             link_send;
    logic [RET_W-1:0] ret_cnt_w;
    logic             rx_pop;
    logic             rx_full;

    cl_tx_credit #(.DEPTH(DEPTH), .RET_W(RET_W)) tx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_valid  (src_valid),
        .ret_cnt    (ret_cnt_w),
        .send       (link_send),
        .has_credit (src_ready),
        .credit     (credit_count),
        .err        (link_err)
    );

    cl_rx_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) rx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (link_send),
        .wr_data  (src_data),
        .rd_ready (dst_ready),
        .rd_valid (dst_valid),
        .rd_data  (dst_data),
        .pop      (rx_pop),
        .full     (rx_full)
    );

    cl_credit_return #(.RET_W(RET_W), .BATCH(BATCH), .MAX_WAIT(MAX_WAIT)) ret_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pop     (rx_pop),
        .ret_cnt (ret_cnt_w)
    );
endmodule

// File: rtl/credit_link_chk.sv
// Module: credit_link_chk
// Property checker for credit_link, attached with bind. Observes the top
// ports plus the link-level send, return count and buffer-full signals.
module credit_link_chk #(
    parameter int DEPTH = 8,
    parameter int RET_W = 4,
    parameter int BATCH = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             src_valid,
    input logic             src_ready,
    input logic             dst_valid,
    input logic             dst_ready,
    input logic [CNT_W-1:0] credit_count,
    input logic             link_err,
    input logic             link_send,
    input logic [RET_W-1:0] ret_cnt,
    input logic             rx_full
);
    // R2: an accepted flit with no return lowers the counter by one.
    p_dec_on_send_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_ready && ret_cnt == '0) |=>
        (int'(credit_count) == int'($past(credit_count)) - 1));

    // R3: a returned count is added, net of a same-cycle send.
    p_add_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_cnt != '0) |=>
        (int'(credit_count) == int'($past(credit_count)) + int'($past(ret_cnt))
                                - int'($past(link_send))));

    // R4: no credit means no ready.
    p_stall_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_count == '0) |-> !src_ready);

    // R4: any credit means ready.
    p_go_on_credit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_count != '0) |-> src_ready);

    // R5: the link never writes into a full buffer.
    p_no_write_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> !link_send);

    // R6: a single return never carries more than one batch.
    p_return_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ret_cnt) <= BATCH);

    // R7: the counter stays within the receiver depth.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(credit_count) <= DEPTH);

    // R7: the error flag, once set, stays set.
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        link_err |=> link_err);

    // R7: legal traffic never raises the error flag.
    p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !link_err);
endmodule

bind credit_link credit_link_chk #(.DEPTH(DEPTH), .RET_W(RET_W), .BATCH(BATCH)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_valid    (src_valid),
    .src_ready    (src_ready),
    .dst_valid    (dst_valid),
    .dst_ready    (dst_ready),
    .credit_count (credit_count),
    .link_err     (link_err),
    .link_send    (link_send),
    .ret_cnt      (ret_cnt_w),
    .rx_full      (rx_full)
);

// File: tb/credit_link_tb_top.sv
// Bench for credit_link: directed corner cases followed by seeded random
// traffic, checked against a queue model and credit expectations.
module credit_link_tb_top;
    localparam int DEPTH  = 8;
    localparam int DATA_W = 16;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              src_valid = 1'b0;
    logic [DATA_W-1:0] src_data = '0;
    logic              src_ready;
    logic              dst_valid;
    logic [DATA_W-1:0] dst_data;
    logic              dst_ready = 1'b0;
    logic [CNT_W-1:0]  credit_count;
    logic              link_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [DATA_W-1:0] model_q[$];
    logic [DATA_W-1:0] next_word = 16'h1000;

    always #5 clk = ~clk;

    credit_link dut_i (
        .clk(clk), .rst_n(rst_n),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .dst_valid(dst_valid), .dst_data(dst_data), .dst_ready(dst_ready),
        .credit_count(credit_count), .link_err(link_err)
    );

    // Expected credit once all returns have drained.
    function automatic int idle_credit(input int held);
        return DEPTH - held;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, score against the model, then clock.
    task automatic step(input bit sv, input bit dr);
        @(negedge clk);
        src_valid = sv;
        dst_ready = dr;
        src_data  = next_word;
        #1;
        check(dst_valid == (model_q.size() != 0), "R5 dst_valid", int'(dst_valid),
              int'(model_q.size() != 0));
        if (model_q.size() == DEPTH)
            check(!src_ready, "R4 stall when full", int'(src_ready), 0);
        if (dst_valid && dr && model_q.size() != 0) begin
            check(dst_data == model_q[0], "R5 order", int'(dst_data), int'(model_q[0]));
            void'(model_q.pop_front());
        end
        if (sv && src_ready) begin
            model_q.push_back(next_word);
            next_word = next_word + 16'd1;
        end
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int c0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2;
        // R1: reset values
        check(credit_count == DEPTH, "R1 credit", int'(credit_count), DEPTH);
        check(src_ready == 1'b1, "R1 src_ready", int'(src_ready), 1);
        check(dst_valid == 1'b0, "R1 dst_valid", int'(dst_valid), 0);
        check(link_err == 1'b0, "R1 err", int'(link_err), 0);
        rst_n = 1'b1;
        step(0, 0);

        // R2: single send
        step(1, 0);
        check(credit_count == 7, "R2 decrement", int'(credit_count), 7);
        for (int i = 0; i < 7; i++) step(1, 0);
        check(credit_count == 0, "R2 drain to zero", int'(credit_count), 0);
        // R4: source pushes with no credit
        step(1, 0);
        check(model_q.size() == DEPTH && credit_count == 0, "R4 no accept at zero",
              int'(credit_count), 0);

        // R6: single freed slot returns by the fifth edge
        step(0, 1);
        for (int i = 0; i < 3; i++) begin
            step(0, 0);
            check(credit_count == 0, "R6 waiting", int'(credit_count), 0);
        end
        check(!src_ready, "R4 still stalled", int'(src_ready), 0);
        step(0, 0);
        check(credit_count == 1, "R6 timeout return", int'(credit_count), 1);
        check(src_ready, "R4 resume", int'(src_ready), 1);

        // R6 batch of two, R3 send in the cycle the batch is applied
        step(0, 1);
        step(0, 1);
        check(credit_count == 1, "R6 batch not yet applied", int'(credit_count), 1);
        step(1, 0);
        check(credit_count == 2, "R3 send plus return", int'(credit_count), 2);

        // R8: drain everything
        for (int i = 0; i < 15; i++) step(0, 1);
        check(credit_count == idle_credit(model_q.size()), "R8 drained",
              int'(credit_count), idle_credit(model_q.size()));
        check(model_q.size() == 0 && !dst_valid, "R5 empty", int'(dst_valid), 0);

        // Random phases with varying densities
        for (int ph = 0; ph < 6; ph++) begin
            int pv = (ph % 3 == 0) ? 90 : 55;
            int pr = (ph % 3 == 0) ? 15 : ((ph % 3 == 1) ? 50 : 85);
            for (int i = 0; i < 500; i++)
                step(($urandom % 100) < pv, ($urandom % 100) < pr);
            c0 = model_q.size();
            for (int i = 0; i < 6; i++) step(0, 0);
            check(credit_count == idle_credit(c0), "R8 idle credit",
                  int'(credit_count), idle_credit(c0));
            check(int'(credit_count) <= DEPTH, "R7 bound", int'(credit_count), DEPTH);
            check(link_err == 1'b0, "R7 no error", int'(link_err), 0);
        end
        for (int i = 0; i < 20; i++) step(0, 1);
        check(credit_count == DEPTH, "R8 final", int'(credit_count), DEPTH);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule